// File: doc/BRIEF.md
# Quad SPI Word Shifter

This block moves one word at a time between a flash controller and a SPI flash bus. The controller presents a 32-bit word together with a length code, a lane-speed select, a direction flag and a hold flag, and pulses a one-cycle strobe. The shifter lowers chip select and clocks the word out from its most significant end, either one bit per SCK on a single lane or four bits per SCK on all four lanes. At the same time it gathers whatever the flash returns and presents it with a one-cycle valid pulse when the word ends.

A word may be strobed while the previous one is still moving. It is then held in a single pending slot and starts on the very edge that ends the current word, so the frame continues with no chip-select gap and no idle clock. Speed and direction are taken per word, so one framed transaction can mix serial command bytes with quad address, dummy and data words. When a word that carries the hold flag ends and nothing is pending, the frame stays open with SCK parked high until the controller sends the next word. Full-stop sequencing in the controller waits for busy low with chip select high.

Top module: `qspi_word_shifter`

## Requirements
- R1: After reset cs_n is 1, sck is 1, busy is 0, valid is 0 and lane_mode is 00.
- R2: len_code 00, 01, 10 and 11 move 8, 16, 24 and 32 bits, taken from bit 31 downward; the unsent low bits of the word never reach the lanes.
- R3: With quad_sel 0 the word moves one bit per SCK cycle, out on dat_o[0] and in from dat_i[1], and lane_mode reads 00 during the word.
- R4: With quad_sel 1 the word moves four bits per SCK cycle, dat_o[3] carrying the most significant bit of each nibble; lane_mode reads 10 for rd_sel 0 and 11 for rd_sel 1, and in a quad read dat_o stays 0000.
- R5: SCK idles high; dat_o changes only at a falling SCK edge or at the edge that loads a word; dat_i is sampled at the rising SCK edge; lane_mode changes only while SCK is low.
- R6: valid is a one-cycle pulse that rises 2 x beats clock cycles after the loading edge (beats = bits for serial, bits/4 for quad); rx_word then holds the received bits with the last one at bit 0 and all unused upper bits 0.
- R7: busy is high from the edge that loads a word until the edge that ends it, and cs_n is low whenever busy is high.
- R8: A strobe taken while a word is moving is queued; the queued word starts on the edge that ends the current one, cs_n stays low across the boundary, and its valid comes 2 x beats cycles after the previous valid.
- R9: When a word with hold_sel 1 ends and nothing is queued, cs_n stays low, sck stays high and busy is low until the next strobe, which continues the same frame.
- R10: When a word with hold_sel 0 ends and nothing is queued, cs_n rises one clock cycle after valid rises, leaving the block idle.
- R11: Speed and direction are taken per word, so words of different lane modes follow each other inside one chip-select frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; SCK runs at half its rate |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle request to move tx_word |
| tx_word | input | 32 | Word to send, most significant bit first |
| len_code | input | 2 | Length select: 8, 16, 24 or 32 bits |
| quad_sel | input | 1 | 1 selects four lanes, 0 selects one |
| rd_sel | input | 1 | 1 makes the lanes inputs in quad mode |
| hold_sel | input | 1 | 1 keeps the frame open after this word |
| sck | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| lane_mode | output | 2 | 00 serial, 10 quad write, 11 quad read |
| dat_o | output | 4 | Data driven onto the lanes |
| dat_i | input | 4 | Data read from the lanes |
| busy | output | 1 | A word is moving |
| valid | output | 1 | One-cycle pulse at the end of each word |
| rx_word | output | 32 | Bits gathered during the last word |

## Verification
Each result has a fixed due cycle counted from the clock edge that takes the strobe: valid is due exactly 2 x beats cycles later (16 for a serial byte or a full quad word, 64 for a full serial word), a queued word's valid 2 x beats cycles after the previous valid, and chip-select release one cycle after valid. The driver works out that cycle when it issues a word and stores it with the expected received word and the expected lane bits, and the monitor compares the cycle count at the pulse against it. Lane bits and lane_mode are captured at falling clock edges while SCK is low, the one phase in which both are settled, and the flash model changes dat_i in that same phase so the block's rising-edge sample sees a stable value.

// File: rtl/qspi_shift_pkg.sv
package qspi_shift_pkg;

  localparam int WORD_BITS = 32;
  localparam int LANES     = 4;
  localparam int BEAT_W    = $clog2(WORD_BITS + 1);

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_RUN,
    SH_PARK,
    SH_TAIL
  } shift_state_t;

  typedef struct packed {
    logic [WORD_BITS-1:0] word;
    logic [1:0]           len;
    logic                 quad;
    logic                 rd;
    logic                 hold;
  } shift_req_t;

  // Number of SCK cycles needed for one word.
  function automatic logic [BEAT_W-1:0] beat_total(input logic [1:0] len, input logic quad);
    logic [BEAT_W-1:0] bits;
    bits = BEAT_W'((int'(len) + 1) * 8);
    return quad ? (bits >> 2) : bits;
  endfunction

  // Lane-mode code shown to the pads.
  function automatic logic [1:0] lane_code(input logic quad, input logic rd);
    if (!quad) return 2'b00;
    return rd ? 2'b11 : 2'b10;
  endfunction

endpackage

// File: rtl/qspi_req_slot.sv
module qspi_req_slot
  import qspi_shift_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set,
  input  logic       clr,
  input  shift_req_t req_in,
  output logic       full,
  output shift_req_t req_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full  <= 1'b0;
      req_q <= '0;
    end else if (set) begin
      full  <= 1'b1;
      req_q <= req_in;
    end else if (clr) begin
      full  <= 1'b0;
    end
  end

  a_r8_slot_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !full);

endmodule

// File: rtl/qspi_lane_shifter.sv
module qspi_lane_shifter #(
  parameter int W = 32,
  parameter int L = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         quad,
  input  logic         shift_out,
  input  logic         sample,
  input  logic [L-1:0] lane_in,
  output logic [L-1:0] lane_top,
  output logic [W-1:0] rx_next
);

  localparam int SER_IN = 1;

  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;

  assign lane_top = tx_q[W-1 -: L];
  assign rx_next  = quad ? {rx_q[W-L-1:0], lane_in} : {rx_q[W-2:0], lane_in[SER_IN]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load) begin
      tx_q <= load_word;
      rx_q <= '0;
    end else begin
      if (shift_out) tx_q <= quad ? (tx_q << L) : (tx_q << 1);
      if (sample)    rx_q <= rx_next;
    end
  end

  a_r5_shift_apart_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_out && sample));

endmodule

// File: rtl/qspi_word_shifter.sv
module qspi_word_shifter
  import qspi_shift_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [WORD_BITS-1:0] tx_word,
  input  logic [1:0]           len_code,
  input  logic                 quad_sel,
  input  logic                 rd_sel,
  input  logic                 hold_sel,
  output logic                 sck,
  output logic                 cs_n,
  output logic [1:0]           lane_mode,
  output logic [LANES-1:0]     dat_o,
  input  logic [LANES-1:0]     dat_i,
  output logic                 busy,
  output logic                 valid,
  output logic [WORD_BITS-1:0] rx_word
);

  shift_state_t         state;
  logic                 sck_q, cs_n_q, fresh_q, valid_q;
  logic [BEAT_W-1:0]    beats_q;
  logic                 quad_q, rd_q, hold_q;
  logic [1:0]           lane_q;
  logic [WORD_BITS-1:0] rx_word_q;

  shift_req_t           in_req, pend_q, next_req;
  logic                 pend_full;

  // Named events used by the datapath and the assertions.
  logic                 in_run, fall_ev, rise_ev, word_end, load_ev, slot_set, slot_clr;
  logic [LANES-1:0]     top_bits;
  logic [WORD_BITS-1:0] rx_next;

  assign in_req   = '{word: tx_word, len: len_code, quad: quad_sel, rd: rd_sel, hold: hold_sel};
  assign in_run   = (state == SH_RUN);
  assign fall_ev  = in_run && sck_q;
  assign rise_ev  = in_run && !sck_q;
  assign word_end = rise_ev && (beats_q == BEAT_W'(1));
  assign next_req = pend_full ? pend_q : in_req;
  assign load_ev  = (!in_run && wr_stb) || (word_end && (pend_full || wr_stb));
  assign slot_set = wr_stb && in_run && !(word_end && !pend_full);
  assign slot_clr = word_end && pend_full;

  qspi_req_slot u_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (slot_set),
    .clr    (slot_clr),
    .req_in (in_req),
    .full   (pend_full),
    .req_q  (pend_q)
  );

  qspi_lane_shifter #(.W(WORD_BITS), .L(LANES)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_ev),
    .load_word (next_req.word),
    .quad      (quad_q),
    .shift_out (fall_ev && !fresh_q),
    .sample    (rise_ev),
    .lane_in   (dat_i),
    .lane_top  (top_bits),
    .rx_next   (rx_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SH_IDLE;
      sck_q     <= 1'b1;
      cs_n_q    <= 1'b1;
      fresh_q   <= 1'b0;
      beats_q   <= '0;
      quad_q    <= 1'b0;
      rd_q      <= 1'b0;
      hold_q    <= 1'b0;
      lane_q    <= 2'b00;
      valid_q   <= 1'b0;
      rx_word_q <= '0;
    end else begin
      valid_q <= word_end;
      if (word_end) rx_word_q <= rx_next;
      if (fall_ev) begin
        sck_q   <= 1'b0;
        fresh_q <= 1'b0;
        lane_q  <= lane_code(quad_q, rd_q);
      end
      if (rise_ev) begin
        sck_q   <= 1'b1;
        beats_q <= beats_q - BEAT_W'(1);
      end
      if (load_ev) begin
        state   <= SH_RUN;
        cs_n_q  <= 1'b0;
        fresh_q <= 1'b1;
        beats_q <= beat_total(next_req.len, next_req.quad);
        quad_q  <= next_req.quad;
        rd_q    <= next_req.rd;
        hold_q  <= next_req.hold;
      end else if (word_end) begin
        state <= hold_q ? SH_PARK : SH_TAIL;
      end else if (state == SH_TAIL) begin
        cs_n_q <= 1'b1;
        state  <= SH_IDLE;
      end
    end
  end

  always_comb begin
    if (!quad_q)   dat_o = {{(LANES-1){1'b0}}, top_bits[LANES-1]};
    else if (rd_q) dat_o = '0;
    else           dat_o = top_bits;
  end

  assign sck       = sck_q;
  assign cs_n      = cs_n_q;
  assign lane_mode = lane_q;
  assign busy      = in_run;
  assign valid     = valid_q;
  assign rx_word   = rx_word_q;

  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SH_IDLE) |-> (cs_n && sck));

  a_r5_lane_mode_low: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode != $past(lane_mode)) |-> !sck);

  a_r5_data_still_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck) && !$past(load_ev)) |-> $stable(dat_o));

  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  a_r7_busy_frames: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);

  a_r8_chain_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end && (pend_full || wr_stb)) |=> (busy && !cs_n));

  a_r9_park_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SH_PARK) |-> (!cs_n && sck && !busy));

endmodule

// File: tb/qspi_word_shifter_test.sv
`timescale 1ns/1ps
module qspi_word_shifter_test;

  typedef struct {
    logic [31:0] rx;
    logic [31:0] tx;
    int          nbeats;
    int          cyc;
    logic [1:0]  lm;
    logic        hold;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [31:0] tx_word = '0;
  logic [1:0]  len_code = '0;
  logic        quad_sel = 1'b0, rd_sel = 1'b0, hold_sel = 1'b0;
  logic        sck, cs_n, busy, valid;
  logic [1:0]  lane_mode;
  logic [3:0]  dat_o;
  logic [3:0]  dat_i = '0;
  logic [31:0] rx_word;

  int   total = 0, fails = 0, cyc = 0;
  int   beat_sum = 0, flash_n = 0, last_exp = 0;
  int   seen_beats = 0, lane_bad = 0, release_at = -1, cs_rises = 0;
  logic [31:0] tx_acc = '0;
  logic last_cs = 1'b1;
  bit   done = 1'b0;
  exp_t sb[$];

  qspi_word_shifter uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .tx_word(tx_word),
    .len_code(len_code), .quad_sel(quad_sel), .rd_sel(rd_sel), .hold_sel(hold_sel),
    .sck(sck), .cs_n(cs_n), .lane_mode(lane_mode), .dat_o(dat_o), .dat_i(dat_i),
    .busy(busy), .valid(valid), .rx_word(rx_word)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] flash_nib(input int n);
    int v;
    v = n * 5 + (n >> 3) + 6;
    return v[3:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Driver: strobe one word and push what the monitor should see.
  task automatic send(input logic [31:0] w, input logic [1:0] len, input logic q,
                      input logic rd, input logic hold, input bit chained);
    exp_t e;
    int   nbits, b;
    nbits = 8 * (int'(len) + 1);
    b     = q ? nbits / 4 : nbits;
    e.rx  = '0;
    for (int k = 0; k < b; k++) begin
      logic [3:0] h;
      h = flash_nib(beat_sum + k);
      e.rx = q ? {e.rx[27:0], h} : {e.rx[30:0], h[1]};
    end
    beat_sum += b;
    e.tx     = (q && rd) ? 32'h0 : (w >> (32 - nbits));
    e.nbeats = b;
    e.lm     = q ? (rd ? 2'b11 : 2'b10) : 2'b00;
    e.hold   = hold;
    if (chained) begin
      for (int t = 0; t < 400 && sb.size() > 1; t++) @(negedge clk);
    end
    @(negedge clk);
    wr_stb = 1'b1; tx_word = w; len_code = len; quad_sel = q; rd_sel = rd; hold_sel = hold;
    @(negedge clk);
    wr_stb = 1'b0;
    e.cyc    = chained ? last_exp + 2 * b : cyc + 2 * b;
    last_exp = e.cyc;
    sb.push_back(e);
  endtask

  task automatic wait_done(input bit parked);
    for (int t = 0; t < 1000; t++) begin
      @(negedge clk);
      if (sb.size() == 0 && (parked || (cs_n && !busy))) break;
    end
    @(negedge clk);
  endtask

  // Monitor and flash model, both working in the SCK-low phase.
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R6", "valid with nothing outstanding", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cyc == e.cyc, "R6", "valid cycle", cyc, e.cyc);
          chk(rx_word == e.rx, "R6", "received word", rx_word, e.rx);
          chk(seen_beats == e.nbeats, "R2", "SCK beats in word", seen_beats, e.nbeats);
          chk(tx_acc == e.tx, e.lm[1] ? "R4" : "R3", "bits on lanes", tx_acc, e.tx);
          chk(lane_bad == 0, "R5", "lane_mode during word", lane_bad, 0);
          tx_acc = '0; seen_beats = 0; lane_bad = 0;
          if (!e.hold && sb.size() == 0) release_at = cyc + 1;
        end
      end
      if (release_at == cyc) begin
        chk(cs_n == 1'b1 && !busy, "R10", "release after valid", {cs_n, busy}, 2'b10);
        release_at = -1;
      end
      if (!cs_n && !sck) begin
        dat_i <= flash_nib(flash_n);
        flash_n++;
        if (sb.size() > 0) begin
          exp_t c;
          c = sb[0];
          tx_acc = c.lm[1] ? {tx_acc[27:0], dat_o} : {tx_acc[30:0], dat_o[0]};
          seen_beats++;
          if (lane_mode != c.lm) lane_bad++;
        end
      end
      if (cs_n && !last_cs) cs_rises++;
      last_cs = cs_n;
    end
  end

  initial begin
    int r0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1", "cs_n after reset", cs_n, 1);
    chk(sck == 1'b1, "R1", "sck after reset", sck, 1);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(valid == 1'b0, "R1", "valid after reset", valid, 0);
    chk(lane_mode == 2'b00, "R1", "lane_mode after reset", lane_mode, 0);

    // R3 R2: serial lengths, including a three-byte word with its low byte dropped
    send(32'hA5C3_1E7F, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(busy && !cs_n, "R7", "busy and cs_n right after load", {busy, cs_n}, 2'b10);
    wait_done(1'b0);
    send(32'h9C3E_0000, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0); wait_done(1'b0);
    send(32'h1234_56AB, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0); wait_done(1'b0);
    send(32'hF00D_CAFE, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0); wait_done(1'b0);

    // R4: quad writes and reads
    send(32'hDEAD_BEEF, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0); wait_done(1'b0);
    send(32'h0123_4567, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0); wait_done(1'b0);
    send(32'h5A00_0000, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0); wait_done(1'b0);
    send(32'h89AB_CD00, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0); wait_done(1'b0);

    // R8 R11: three chained words with changing speed and direction
    r0 = cs_rises;
    send(32'hEB00_0000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    send(32'h3C5A_96A0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1);
    send(32'h0000_0000, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1);
    wait_done(1'b0);
    chk(cs_rises == r0 + 1, "R8", "cs_n rises once over chained frame", cs_rises, r0 + 1);

    // R9 R11: parked frame continued by a quad word
    r0 = cs_rises;
    send(32'h0B00_0000, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0);
    wait_done(1'b1);
    repeat (6) @(negedge clk);
    chk(cs_n == 1'b0, "R9", "cs_n while parked", cs_n, 0);
    chk(sck == 1'b1, "R9", "sck while parked", sck, 1);
    chk(busy == 1'b0, "R9", "busy while parked", busy, 0);
    send(32'h7E81_42BD, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0);
    wait_done(1'b0);
    chk(cs_rises == r0 + 1, "R9", "cs_n rises once over parked frame", cs_rises, r0 + 1);
    chk(sb.size() == 0, "R6", "all words answered", sb.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule